// File: doc/BRIEF.md
# Fracturable Look-Up Slice Function Generator

This block is the logic part of one configurable slice. It holds four function generators, A, B, C and D. Each generator is a six-input look-up table set by a 64-bit configuration word. A generator can produce one function of all six inputs. It can also be split into two functions of up to five inputs that share inputs 1 to 5; in that case input 6 is tied high. A slice can also combine its tables into one wider function. Two seven-input multiplexers each join the full-width outputs of a neighbouring pair of generators. An eight-input multiplexer then joins those two results, so all four tables act as one eight-input function.

All outputs are registered once, with a synchronous active-high reset. Every output therefore has the same one-cycle latency, whatever function is loaded. The configuration words are static inputs, meant to be driven from configuration storage outside the block. To build a function wider than eight inputs, several instances must be joined outside this block.

Top module: `frac_slice_fgen`

## Requirements
- R1: One clock edge with `rst` high sets every output (`o6_q`, `o5_q`, `mux7_q`, `mux8_q`) to 0. This holds for any input values.
- R2: The full output of generator g gives bit `cfg_i[64*g + a]`. Here a is the 6-bit address `addr_i[6*g +: 6]`. Input 1 is the least significant bit and input 6 is the most significant bit.
- R3: The split output of generator g gives bit `cfg_i[64*g + (a mod 32)]`, which uses only the lower 32 bits of the word. Input 6 has no effect on it.
- R4: In dual-output mode (input 6 high), the full output gives the upper-half bit `cfg_i[64*g + 32 + (a mod 32)]`. The split output gives the lower-half bit for the same inputs 1 to 5. When input 6 is low, both outputs are equal.
- R5: `mux7_q[0]` gives the full output of generator B when `byp_i[0]` (the A-position bypass) is 1, and the full output of generator A when it is 0.
- R6: `mux7_q[1]` gives the full output of generator D when `byp_i[2]` (the C-position bypass) is 1, and the full output of generator C when it is 0.
- R7: `mux8_q` gives `mux7_q[1]` when `byp_i[1]` (the B-position bypass) is 1, and `mux7_q[0]` when it is 0. With the same six inputs on every generator, this makes an eight-input function indexed by {`byp_i[1]`, `byp_i[0]`=`byp_i[2]`, inputs 6..1}.
- R8: Every output changes exactly one rising edge after its inputs change, and holds its value until that edge.
- R9: The outputs of each generator depend only on that generator's own address and configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 24 | Six address inputs per generator; generator g uses bits [6g+5:6g], input 1 in the low bit |
| byp_i | input | 4 | Per-generator bypass input; bits 0, 2 select the seven-input muxes, bit 1 the eight-input mux |
| cfg_i | input | 256 | Static 64-bit configuration word per generator; generator g uses bits [64g+63:64g] |
| o6_q | output | 4 | Registered full (six-input) output per generator |
| o5_q | output | 4 | Registered split (five-input) output per generator |
| mux7_q | output | 2 | Registered seven-input mux outputs (pair A/B, pair C/D) |
| mux8_q | output | 1 | Registered eight-input mux output |

## Verification
Some properties are checked by assertions on every cycle:
- the reset clearing;
- how each wide multiplexer follows its select into the correct table or pair output;
- that the split and full outputs are equal whenever input 6 is low or the two halves of the word are the same.

The bench's scenarios cover what the assertions cannot:
- that each table bit is indexed correctly under random configuration words;
- that every one of the 256 combinations of the eight-input function is right;
- that the one-cycle hold before each update is correct;
- that one generator cannot disturb another.

// File: rtl/fslice_pkg.sv
package fslice_pkg;
  localparam int unsigned GEN_COUNT = 4;
  localparam int unsigned TABLE_INPUTS = 6;
  typedef enum logic [1:0] {GEN_A = 2'd0, GEN_B = 2'd1, GEN_C = 2'd2, GEN_D = 2'd3} gen_pos_e;
endpackage

// File: rtl/frac_lut.sv
module frac_lut #(
  parameter int unsigned K = 6,
  localparam int unsigned WORD_W = 1 << K
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [K-1:0]      sel_i,
  output logic              full_o,
  output logic              half_o
);
  logic [WORD_W/2-1:0] low_half;

  assign low_half = word_i[WORD_W/2-1:0];
  assign full_o   = word_i[sel_i];
  assign half_o   = low_half[sel_i[K-2:0]];
endmodule

// File: rtl/fslice_wide_mux.sv
module fslice_wide_mux #(
  parameter int unsigned N = 4,
  localparam int unsigned PAIRS = N / 2
) (
  input  logic [N-1:0]     full_i,
  input  logic [N-1:0]     byp_i,
  output logic [PAIRS-1:0] m7_o,
  output logic             m8_o
);
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign m7_o[p] = byp_i[2*p] ? full_i[2*p+1] : full_i[2*p];
  end

  assign m8_o = byp_i[1] ? m7_o[1] : m7_o[0];
endmodule

// File: rtl/frac_slice_fgen.sv
module frac_slice_fgen #(
  parameter int unsigned NGEN = fslice_pkg::GEN_COUNT,
  parameter int unsigned K    = fslice_pkg::TABLE_INPUTS,
  localparam int unsigned WORD_W = 1 << K,
  localparam int unsigned PAIRS  = NGEN / 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NGEN*K-1:0]      addr_i,
  input  logic [NGEN-1:0]        byp_i,
  input  logic [NGEN*WORD_W-1:0] cfg_i,
  output logic [NGEN-1:0]        o6_q,
  output logic [NGEN-1:0]        o5_q,
  output logic [PAIRS-1:0]       mux7_q,
  output logic                   mux8_q
);
  logic [NGEN-1:0]  full_c;
  logic [NGEN-1:0]  half_c;
  logic [PAIRS-1:0] m7_c;
  logic             m8_c;

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    frac_lut #(.K(K)) u_lut (
      .word_i (cfg_i[g*WORD_W +: WORD_W]),
      .sel_i  (addr_i[g*K +: K]),
      .full_o (full_c[g]),
      .half_o (half_c[g])
    );
  end

  fslice_wide_mux #(.N(NGEN)) u_wide (
    .full_i (full_c),
    .byp_i  (byp_i),
    .m7_o   (m7_c),
    .m8_o   (m8_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o6_q   <= '0;
      o5_q   <= '0;
      mux7_q <= '0;
      mux8_q <= 1'b0;
    end else begin
      o6_q   <= full_c;
      o5_q   <= half_c;
      mux7_q <= m7_c;
      mux8_q <= m8_c;
    end
  end
endmodule

// File: rtl/frac_slice_fgen_chk.sv
module frac_slice_fgen_chk #(
  parameter int unsigned NGEN = 4,
  parameter int unsigned K    = 6,
  localparam int unsigned WORD_W = 1 << K,
  localparam int unsigned PAIRS  = NGEN / 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NGEN*K-1:0]      addr_i,
  input logic [NGEN-1:0]        byp_i,
  input logic [NGEN*WORD_W-1:0] cfg_i,
  input logic [NGEN-1:0]        o6_q,
  input logic [NGEN-1:0]        o5_q,
  input logic [PAIRS-1:0]       mux7_q,
  input logic                   mux8_q
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (o6_q == '0 && o5_q == '0 && mux7_q == '0 && !mux8_q));

  for (genvar g = 0; g < NGEN; g++) begin : g_lut_chk
    // R4: with input 6 low both outputs index the same lower-half bit
    a_r4_low_half_match: assert property (@(posedge clk) disable iff (rst)
      !addr_i[g*K + K - 1] |=> (o5_q[g] == o6_q[g]));
    // R3: identical halves make the split output equal to the full output
    a_r3_equal_halves: assert property (@(posedge clk) disable iff (rst)
      (cfg_i[g*WORD_W +: WORD_W/2] == cfg_i[g*WORD_W + WORD_W/2 +: WORD_W/2])
      |=> (o5_q[g] == o6_q[g]));
  end

  a_r5_mux7_upper: assert property (@(posedge clk) disable iff (rst)
    byp_i[0] |=> (mux7_q[0] == o6_q[1]));
  a_r5_mux7_lower: assert property (@(posedge clk) disable iff (rst)
    !byp_i[0] |=> (mux7_q[0] == o6_q[0]));
  a_r6_mux7_upper: assert property (@(posedge clk) disable iff (rst)
    byp_i[2] |=> (mux7_q[1] == o6_q[3]));
  a_r6_mux7_lower: assert property (@(posedge clk) disable iff (rst)
    !byp_i[2] |=> (mux7_q[1] == o6_q[2]));
  a_r7_mux8_upper: assert property (@(posedge clk) disable iff (rst)
    byp_i[1] |=> (mux8_q == mux7_q[1]));
  a_r7_mux8_lower: assert property (@(posedge clk) disable iff (rst)
    !byp_i[1] |=> (mux8_q == mux7_q[0]));
endmodule

bind frac_slice_fgen frac_slice_fgen_chk #(.NGEN(NGEN), .K(K)) u_chk (
  .clk(clk), .rst(rst), .addr_i(addr_i), .byp_i(byp_i), .cfg_i(cfg_i),
  .o6_q(o6_q), .o5_q(o5_q), .mux7_q(mux7_q), .mux8_q(mux8_q)
);

// File: tb/tb_frac_slice_fgen.sv
`timescale 1ns/1ps
module tb_frac_slice_fgen;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [23:0]  addr_i = '0;
  logic [3:0]   byp_i = '0;
  logic [255:0] cfg_i = '0;
  logic [3:0]   o6_q, o5_q;
  logic [1:0]   mux7_q;
  logic         mux8_q;

  int total = 0;
  int bad = 0;
  logic [63:0] cfgm [4];
  int          adm  [4];
  int          bypm;
  logic [3:0]  prev6, prev5;
  logic [1:0]  prev7;
  logic        prev8;

  always #4 clk = ~clk;

  frac_slice_fgen dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .byp_i(byp_i), .cfg_i(cfg_i),
    .o6_q(o6_q), .o5_q(o5_q), .mux7_q(mux7_q), .mux8_q(mux8_q)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic ref6(input int g);
    return cfgm[g][adm[g]];
  endfunction
  function automatic logic ref5(input int g);
    return cfgm[g][adm[g] % 32];
  endfunction
  function automatic logic ref7(input int p);
    int sel = (p == 0) ? (bypm & 1) : ((bypm >> 2) & 1);
    return ref6(2*p + sel);
  endfunction
  function automatic logic ref8();
    return ref7((bypm >> 1) & 1);
  endfunction

  task automatic drive();
    for (int g = 0; g < 4; g++) begin
      cfg_i[64*g +: 64] = cfgm[g];
      addr_i[6*g +: 6]  = 6'(adm[g]);
    end
    byp_i = 4'(bypm);
  endtask

  // drive at negedge, check hold before the edge (R8), then compare after it
  task automatic apply(input string tag);
    @(negedge clk);
    prev6 = o6_q; prev5 = o5_q; prev7 = mux7_q; prev8 = mux8_q;
    drive();
    #1;
    chk({"R8 hold ", tag}, {o6_q, o5_q, mux7_q, mux8_q}, {prev6, prev5, prev7, prev8});
    @(posedge clk);
    #1;
    for (int g = 0; g < 4; g++) begin
      chk({"R2 o6 ", tag}, o6_q[g], ref6(g));
      chk({"R3 o5 ", tag}, o5_q[g], ref5(g));
    end
    chk({"R5 mux7a ", tag}, mux7_q[0], ref7(0));
    chk({"R6 mux7b ", tag}, mux7_q[1], ref7(1));
    chk({"R7 mux8 ", tag}, mux8_q, ref8());
  endtask

  task automatic randomize_all();
    for (int g = 0; g < 4; g++) begin
      cfgm[g] = {$urandom, $urandom};
      adm[g]  = $urandom % 64;
    end
    bypm = $urandom % 16;
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset with busy inputs
    for (int g = 0; g < 4; g++) begin cfgm[g] = '1; adm[g] = 63; end
    bypm = 15;
    drive();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", {o6_q, o5_q, mux7_q, mux8_q}, 0);
    @(negedge clk);
    rst = 1'b0;

    // R2/R3/R5/R6/R7: random words and addresses
    for (int i = 0; i < 200; i++) begin
      randomize_all();
      apply("random");
    end

    // R4: dual mode, input 6 high, distinct halves
    for (int i = 0; i < 32; i++) begin
      randomize_all();
      for (int g = 0; g < 4; g++) begin
        adm[g]  = 32 + i;
        cfgm[g] = {~cfgm[g][31:0], cfgm[g][31:0]};
      end
      apply("dual");
      for (int g = 0; g < 4; g++) begin
        chk("R4 dual o6 upper", o6_q[g], cfgm[g][32 + i]);
        chk("R4 dual o5 lower", o5_q[g], cfgm[g][i]);
        chk("R4 dual outputs differ", o6_q[g] ^ o5_q[g], 1);
      end
    end

    // R3: input 6 toggled alone leaves o5 unchanged
    randomize_all();
    adm[0] = 5;
    apply("in6 low");
    prev5 = o5_q;
    adm[0] = 37;
    apply("in6 high");
    chk("R3 input6 ignored by o5", o5_q[0], prev5[0]);

    // R7: exhaustive eight-input function, all generators share inputs 1-6
    randomize_all();
    for (int v = 0; v < 256; v++) begin
      for (int g = 0; g < 4; g++) adm[g] = v % 64;
      bypm = (((v >> 7) & 1) << 1) | ((v >> 6) & 1) | (((v >> 6) & 1) << 2);
      apply("eight-input sweep");
      chk("R7 eight-input index", mux8_q, cfgm[v >> 6][v % 64]);
    end

    // R9: changing generator C only leaves A, B, D untouched
    randomize_all();
    apply("indep base");
    prev6 = o6_q; prev5 = o5_q;
    cfgm[2] = ~cfgm[2];
    adm[2]  = (adm[2] + 17) % 64;
    apply("indep change");
    chk("R9 others unaffected", {o6_q[3], o6_q[1:0], o5_q[3], o5_q[1:0]},
        {prev6[3], prev6[1:0], prev5[3], prev5[1:0]});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule